// File: doc/BRIEF.md
# Mixed Index and Short-ALU Codeword Expander

The expander sits between the fetch of a compressed 16-bit code stream and the instruction fetch of a wide-word processor. Each accepted codeword is one of two kinds. It can be a lookup request, which carries a 15-bit position in an external dictionary of full instructions. It can also be a short ALU operation: a 3-bit operation selector and three 4-bit register numbers. A short operation is expanded on the spot into a complete 48-bit instruction. The selector picks one of eight opcode templates, and the register numbers are ORed into fixed bit fields of that template.

The eight templates are held in a small writable table, so each program can choose the eight operations that compress it best. Software loads an entry through a write port: an enable, a 3-bit entry number and a 48-bit template. Every accepted codeword produces exactly one single-cycle pulse, one clock after it is accepted. The pulse comes on either the index channel or the instruction channel.

Control is a three-state machine whose state names the kind of output presented in the current cycle:
- **IDLE**: neither valid output is high.
- **INDEX**: `idx_valid` is high.
- **ALU**: `ins_valid` is high.

From any state, the machine moves as follows on each clock:
- To INDEX when a codeword with bit 15 clear is accepted.
- To ALU when a codeword with bit 15 set is accepted.
- To IDLE when `cw_valid` is low.

Top module: `cw_expander`

## Requirements
- R1: A codeword accepted with bit 15 = 0 raises `idx_valid` for exactly one cycle, in the cycle after acceptance, with `idx_value` equal to codeword bits 14:0.
- R2: A codeword accepted with bit 15 = 1 raises `ins_valid` for exactly one cycle, in the cycle after acceptance. `ins_word` equals the template selected by codeword bits 14:12, ORed with the register fields of R3.
- R3: In a short ALU codeword, bits 11:8 (destination) go to `ins_word` bits 27:24. Bits 7:4 (source X) go to bits 23:20, and bits 3:0 (source Y) go to bits 19:16.
- R4: The selector in bits 14:12 addresses all eight template entries independently, with entry n chosen by selector value n.
- R5: `idx_valid` and `ins_valid` are never high together. Neither is high in the cycle after a cycle with `cw_valid` low.
- R6: A template written in cycle w is used by a codeword accepted in cycle w+1. A codeword accepted in the same cycle as the write uses the previous contents.
- R7: After reset, both valid outputs are low and every template entry holds the no-operation word 48'h5A5A_0000_0001.
- R8: A template write raises no valid output and leaves the other seven entries unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cw_valid | input | 1 | Codeword present this cycle |
| cw_data | input | 16 | Codeword |
| tw_en | input | 1 | Template write enable |
| tw_sel | input | 3 | Template entry to write |
| tw_data | input | 48 | Template value (register fields zero) |
| idx_valid | output | 1 | Dictionary lookup request pulse |
| idx_value | output | 15 | Dictionary position |
| ins_valid | output | 1 | Expanded instruction pulse |
| ins_word | output | 48 | Expanded 48-bit instruction |

## Verification
The bench mixes index and ALU codewords back to back. A design with a stuck or shared state would then drop a pulse, or raise both valids at once. It sends the extreme index values 0 and 7FFF, which expose a lost or shifted bit, and it uses distinct register nibbles so that any swap of the destination and source fields shows up. It writes a template in the same cycle as a codeword and then in the cycle before one. This separates a table that forwards early or lags by a cycle from a correct one. It also reads all eight entries after a single write, which catches a decoder that writes more than one entry.

// File: rtl/cwx_pkg.sv
package cwx_pkg;
    localparam int CW_W     = 16;
    localparam int IDX_W    = CW_W - 1;
    localparam int OP_W     = 3;
    localparam int OPS      = 1 << OP_W;
    localparam int REG_W    = 4;
    localparam int INS_W    = 48;
    localparam int DST_LSB  = 24;
    localparam int SRCX_LSB = 20;
    localparam int SRCY_LSB = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INDEX = 2'd1,
        ST_ALU   = 2'd2
    } cwx_state_e;

    typedef struct packed {
        logic               is_alu;
        logic [OP_W-1:0]    op;
        logic [REG_W-1:0]   dst;
        logic [REG_W-1:0]   srcx;
        logic [REG_W-1:0]   srcy;
        logic [IDX_W-1:0]   index;
    } cwx_fields_t;
endpackage

// File: rtl/cwx_field_split.sv
module cwx_field_split
    import cwx_pkg::*;
(
    input  logic [CW_W-1:0] cw,
    output cwx_fields_t     fields
);
    always_comb begin
        fields.is_alu = cw[CW_W-1];
        fields.index  = cw[IDX_W-1:0];
        fields.op     = cw[CW_W-2 -: OP_W];
        fields.dst    = cw[3*REG_W-1 -: REG_W];
        fields.srcx   = cw[2*REG_W-1 -: REG_W];
        fields.srcy   = cw[REG_W-1:0];
    end
endmodule

// File: rtl/cwx_tmpl_table.sv
module cwx_tmpl_table #(
    parameter int          ENTRIES   = 8,
    parameter int          WIDTH     = 48,
    parameter logic [47:0] RESET_VAL = 48'h5A5A_0000_0001
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(ENTRIES)-1:0] wr_sel,
    input  logic [WIDTH-1:0]           wr_data,
    input  logic [$clog2(ENTRIES)-1:0] rd_sel,
    output logic [WIDTH-1:0]           rd_data
);
    logic [WIDTH-1:0] entry_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q[e] <= RESET_VAL[WIDTH-1:0];
            end else if (wr_en && (wr_sel == e[$clog2(ENTRIES)-1:0])) begin
                entry_q[e] <= wr_data;
            end
        end
    end

    assign rd_data = entry_q[rd_sel];
endmodule

// File: rtl/cwx_merge.sv
module cwx_merge
    import cwx_pkg::*;
(
    input  logic [INS_W-1:0] tmpl,
    input  logic [REG_W-1:0] dst,
    input  logic [REG_W-1:0] srcx,
    input  logic [REG_W-1:0] srcy,
    output logic [INS_W-1:0] word
);
    logic [INS_W-1:0] reg_bits;

    always_comb begin
        reg_bits = '0;
        reg_bits[DST_LSB  +: REG_W] = dst;
        reg_bits[SRCX_LSB +: REG_W] = srcx;
        reg_bits[SRCY_LSB +: REG_W] = srcy;
        word = tmpl | reg_bits;
    end
endmodule

// File: rtl/cw_expander.sv
module cw_expander
    import cwx_pkg::*;
#(
    parameter logic [47:0] NOP_WORD = 48'h5A5A_0000_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cw_valid,
    input  logic [15:0]       cw_data,
    input  logic              tw_en,
    input  logic [2:0]        tw_sel,
    input  logic [47:0]       tw_data,
    output logic              idx_valid,
    output logic [14:0]       idx_value,
    output logic              ins_valid,
    output logic [47:0]       ins_word
);
    cwx_fields_t      fields;
    logic [INS_W-1:0] tmpl;
    logic [INS_W-1:0] merged;
    cwx_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [INS_W-1:0] ins_q;

    cwx_field_split u_split (
        .cw     (cw_data),
        .fields (fields)
    );

    cwx_tmpl_table #(
        .ENTRIES   (OPS),
        .WIDTH     (INS_W),
        .RESET_VAL (NOP_WORD)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tw_en),
        .wr_sel  (tw_sel),
        .wr_data (tw_data),
        .rd_sel  (fields.op),
        .rd_data (tmpl)
    );

    cwx_merge u_merge (
        .tmpl (tmpl),
        .dst  (fields.dst),
        .srcx (fields.srcx),
        .srcy (fields.srcy),
        .word (merged)
    );

    // Next state: the kind of the codeword accepted this cycle.
    always_comb begin
        state_d = ST_IDLE;
        if (cw_valid) begin
            state_d = fields.is_alu ? ST_ALU : ST_INDEX;
        end
    end

    // State register with its payload registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            ins_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_INDEX) idx_q <= fields.index;
            if (state_d == ST_ALU)   ins_q <= merged;
        end
    end

    // Outputs from the current state.
    always_comb begin
        idx_valid = 1'b0;
        ins_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_INDEX: idx_valid = 1'b1;
            ST_ALU:   ins_valid = 1'b1;
            default:  ;
        endcase
    end

    assign idx_value = idx_q;
    assign ins_word  = ins_q;
endmodule

// File: rtl/cwx_checker.sv
module cwx_checker
    import cwx_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        cw_valid,
    input logic [15:0] cw_data,
    input logic        tw_en,
    input logic        idx_valid,
    input logic [14:0] idx_value,
    input logic        ins_valid,
    input logic [47:0] ins_word
);
    AST_VALID_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(idx_valid && ins_valid)); // R5

    AST_NO_INPUT_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !cw_valid |=> (!idx_valid && !ins_valid)); // R5

    AST_INDEX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid && !cw_data[15]) |=> (idx_valid && idx_value == $past(cw_data[14:0]))); // R1

    AST_ALU_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid && cw_data[15]) |=> (ins_valid && !idx_valid)); // R2

    AST_ALU_DST_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid && cw_data[15]) |=>
        ((ins_word[DST_LSB +: REG_W] & $past(cw_data[11:8])) == $past(cw_data[11:8]))); // R3

    AST_ALU_SRC_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid && cw_data[15]) |=>
        (((ins_word[SRCX_LSB +: REG_W] & $past(cw_data[7:4])) == $past(cw_data[7:4])) &&
         ((ins_word[SRCY_LSB +: REG_W] & $past(cw_data[3:0])) == $past(cw_data[3:0])))); // R3

    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (tw_en && !cw_valid) |=> (!idx_valid && !ins_valid)); // R8
endmodule

bind cw_expander cwx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cw_valid  (cw_valid),
    .cw_data   (cw_data),
    .tw_en     (tw_en),
    .idx_valid (idx_valid),
    .idx_value (idx_value),
    .ins_valid (ins_valid),
    .ins_word  (ins_word)
);

// File: tb/cw_expander_test.sv
`timescale 1ns/1ps
module cw_expander_test;
    localparam logic [47:0] NOP = 48'h5A5A_0000_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cw_valid = 1'b0;
    logic [15:0] cw_data = '0;
    logic        tw_en = 1'b0;
    logic [2:0]  tw_sel = '0;
    logic [47:0] tw_data = '0;
    logic        idx_valid, ins_valid;
    logic [14:0] idx_value;
    logic [47:0] ins_word;

    int checks = 0;
    int failures = 0;
    logic [47:0] model [8];

    always #4 clk = ~clk;

    cw_expander uut (
        .clk(clk), .rst_n(rst_n), .cw_valid(cw_valid), .cw_data(cw_data),
        .tw_en(tw_en), .tw_sel(tw_sel), .tw_data(tw_data),
        .idx_valid(idx_valid), .idx_value(idx_value),
        .ins_valid(ins_valid), .ins_word(ins_word)
    );

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [47:0] expand(input logic [15:0] cw);
        logic [47:0] w;
        w = model[cw[14:12]];
        w[27:24] = w[27:24] | cw[11:8];
        w[23:20] = w[23:20] | cw[7:4];
        w[19:16] = w[19:16] | cw[3:0];
        return w;
    endfunction

    // Present one codeword, then check the pulse in the following cycle.
    task automatic send(input string req, input logic [15:0] cw);
        @(negedge clk);
        cw_valid = 1'b1; cw_data = cw;
        @(negedge clk);
        cw_valid = 1'b0; cw_data = '0;
        if (cw[15]) begin
            check({req, " ins_valid"}, {47'd0, ins_valid}, 48'd1);
            check({req, " idx_valid"}, {47'd0, idx_valid}, 48'd0);
            check({req, " ins_word"}, ins_word, expand(cw));
        end else begin
            check({req, " idx_valid"}, {47'd0, idx_valid}, 48'd1);
            check({req, " ins_valid"}, {47'd0, ins_valid}, 48'd0);
            check({req, " idx_value"}, {33'd0, idx_value}, {33'd0, cw[14:0]});
        end
        @(negedge clk);
        check({req, " pulse ends"}, {46'd0, idx_valid, ins_valid}, 48'd0);
    endtask

    task automatic write_tmpl(input logic [2:0] sel, input logic [47:0] val);
        @(negedge clk);
        tw_en = 1'b1; tw_sel = sel; tw_data = val;
        @(negedge clk);
        tw_en = 1'b0;
        model[sel] = val;
    endtask

    task automatic t_reset;
        check("R7 reset idx_valid", {47'd0, idx_valid}, 48'd0);
        check("R7 reset ins_valid", {47'd0, ins_valid}, 48'd0);
        for (int i = 0; i < 8; i++) send("R7 nop template", {1'b1, 3'(i), 12'h000});
    endtask

    task automatic t_index;
        send("R1 index zero", 16'h0000);
        send("R1 index max", 16'h7FFF);
        send("R1 index pattern", 16'h2A5C);
    endtask

    task automatic t_ops;
        for (int i = 0; i < 8; i++)
            write_tmpl(3'(i), {8'(8'h10 + i), 12'h0, 8'(i), 4'h0, 12'h000, 4'(i)} & 48'hFFFF_F000_FFFF);
        for (int i = 0; i < 8; i++) send("R4 selector", {1'b1, 3'(i), 12'h3C5});
        send("R2 alu expand", 16'hD9A1);
    endtask

    task automatic t_fields;
        send("R3 dst field", {1'b1, 3'd2, 4'hF, 4'h0, 4'h0});
        send("R3 srcx field", {1'b1, 3'd2, 4'h0, 4'hF, 4'h0});
        send("R3 srcy field", {1'b1, 3'd2, 4'h0, 4'h0, 4'hF});
        send("R3 mixed regs", {1'b1, 3'd5, 4'h1, 4'h2, 4'h4});
    endtask

    task automatic t_stream;
        logic [15:0] seq [6];
        logic [15:0] prev;
        logic        pv;
        seq[0] = 16'h0123; seq[1] = 16'h8123; seq[2] = 16'hF456;
        seq[3] = 16'h7ABC; seq[4] = 16'h0001; seq[5] = 16'hA789;
        pv = 1'b0; prev = '0;
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            if (pv) begin
                check("R5 exclusive", {46'd0, idx_valid, ins_valid},
                      prev[15] ? 48'd1 : 48'd2);
                if (prev[15]) check("R2 stream word", ins_word, expand(prev));
                else check("R1 stream index", {33'd0, idx_value}, {33'd0, prev[14:0]});
            end
            if (i < 6) begin
                cw_valid = 1'b1; cw_data = seq[i]; prev = seq[i]; pv = 1'b1;
            end else begin
                cw_valid = 1'b0; cw_data = '0;
            end
        end
        @(negedge clk);
        check("R5 idle after gap", {46'd0, idx_valid, ins_valid}, 48'd0);
    endtask

    task automatic t_write_timing;
        logic [47:0] oldv;
        oldv = model[3];
        // Same-cycle write and codeword: old contents used.
        @(negedge clk);
        tw_en = 1'b1; tw_sel = 3'd3; tw_data = 48'h0C0C_0000_C0C0;
        cw_valid = 1'b1; cw_data = 16'hB000;
        @(negedge clk);
        tw_en = 1'b0;
        cw_data = 16'hB000;          // codeword in the cycle right after the write
        check("R6 same-cycle uses old", ins_word, oldv);
        model[3] = 48'h0C0C_0000_C0C0;
        @(negedge clk);
        cw_valid = 1'b0;
        check("R6 next-cycle uses new", ins_word, 48'h0C0C_0000_C0C0);
    endtask

    task automatic t_write_quiet;
        @(negedge clk);
        tw_en = 1'b1; tw_sel = 3'd6; tw_data = 48'hABCD_E000_1234;
        @(negedge clk);
        tw_en = 1'b0;
        model[6] = 48'hABCD_E000_1234;
        check("R8 write raises no valid", {46'd0, idx_valid, ins_valid}, 48'd0);
        for (int i = 0; i < 8; i++) send("R8 other entries kept", {1'b1, 3'(i), 12'h000});
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = NOP;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_index();
        t_ops();
        t_fields();
        t_stream();
        t_write_timing();
        t_write_quiet();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule